// File: doc/BRIEF.md
# Hamming Syndrome Decoder and Single-Bit Corrector

This block checks one or two 256-byte data chunks after a flash page read. For each chunk it takes the 22-bit Hamming code that was computed over the data as it streamed in, and the 22-bit code that was stored beside the data. It forms the syndrome, which is the XOR of the two codes, and sorts the outcome into one of four classes. For a correctable data error it also reports where the bad bit is.

A pulse on `start` loads every code. Two clocks later `done` pulses for one cycle. From then until the next `done`, the status and error locations hold steady. The outputs report the merged status, the status of each chunk, and each chunk's failing byte offset and bit index.

A second path repairs data in a buffer. Software streams bytes through the correction port with a byte address. Each byte comes back one clock later, with the flagged bit inverted when the address names a correctable location. The correction port uses valid/ready on both sides and holds its output while the consumer stalls.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: Chunk c takes its codes from bits [24c+23:24c] of `calc_code` and of `stored_code`. Byte k of the code sits at bits [8k+7:8k] of that slice, so the code is little-endian. Only the low 22 bits of the slice are used, and the top two bits of byte 2 have no effect on any result.
- R2: `done` pulses for one cycle two clock edges after the edge that samples `start` high. Status and location outputs stay constant until the next `done`.
- R3: A chunk reports status 0 (no error) when its syndrome is zero, or when either of its two codes is all zero.
- R4: A chunk reports status 1 (error in the check bits only) when its syndrome has exactly one bit set and rule R3 does not apply.
- R5: A chunk reports status 2 (correctable) when two conditions hold: its syndrome has exactly eleven bits set, and the syndrome's bits [10:0] are the bitwise complement of its bits [21:11]. For that chunk, `err_bit` is syndrome bits [2:0] and `err_offset` is syndrome bits [10:3].
- R6: A chunk reports status 3 (uncorrectable) for any syndrome that R3 to R5 do not cover. This includes eleven set bits whose two halves are not complementary.
- R7: When `dual_mode` is sampled low with `start`, chunk 1 is ignored and its `chunk_status` reads 0. The merged `status` is the numerically highest status among the enabled chunks, so either half failing gives 3.
- R8: The correction port returns the input byte with bit `err_bit` inverted only in one case: the address chunk index (bit 8) names a chunk with status 2, and the address bits [7:0] equal that chunk's `err_offset`. Every other byte passes through unchanged.
- R9: Back-pressure rules for the correction port:
  - `fix_ready` equals `!fixo_valid || fixo_ready`.
  - A byte is accepted when `fix_valid && fix_ready`.
  - The result appears on `fixo_valid`/`fixo_data` one clock after acceptance.
  - While `fixo_valid && !fixo_ready`, both outputs hold stable.
- R10: During reset, `done` is 0, `status` and all chunk statuses are 0, and `fixo_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads all codes and starts a decode |
| dual_mode | input | 1 | Enables chunk 1 (512-byte page) |
| calc_code | input | 48 | Calculated codes, 24 bits per chunk, little-endian bytes |
| stored_code | input | 48 | Stored codes, same layout |
| done | output | 1 | One-cycle result pulse |
| status | output | 2 | Merged status: 0 none, 1 check bits, 2 correctable, 3 uncorrectable |
| chunk_status | output | 4 | Status per chunk, 2 bits each |
| err_offset | output | 16 | Failing byte offset per chunk, 8 bits each |
| err_bit | output | 6 | Failing bit index per chunk, 3 bits each |
| fix_valid | input | 1 | Correction input byte valid |
| fix_ready | output | 1 | Correction input can accept |
| fix_addr | input | 9 | Chunk index (bit 8) and byte offset |
| fix_data | input | 8 | Byte to correct |
| fixo_valid | output | 1 | Corrected byte valid |
| fixo_ready | input | 1 | Consumer accepts corrected byte |
| fixo_data | output | 8 | Corrected byte |

## Verification
The hardest case to reach is a syndrome that is correctable: exactly eleven set bits, with the two halves complementary. Random codes almost never produce one. The stimulus therefore builds each stored code from the calculated code XOR a chosen error location placed in the low half, with that location's complement in the high half.

The same construction, with one half altered to break the complement while the bit count stays at eleven, produces the near miss that must be reported as uncorrectable. The correction port is then driven at the reported offset, at a neighbouring offset, and at the disabled chunk, including a stalled consumer.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
  localparam int CODE_W     = 22;
  localparam int HALF_W     = CODE_W / 2;
  localparam int BYTE_W     = 8;
  localparam int CODE_BYTES = 3;
  localparam int BIT_W      = 3;
  localparam int OFFS_W     = HALF_W - BIT_W;
  localparam int POP_W      = $clog2(CODE_W + 1);

  typedef enum logic [1:0] {
    ST_NONE   = 2'd0,
    ST_ECC    = 2'd1,
    ST_CORR   = 2'd2,
    ST_UNCORR = 2'd3
  } ecc_status_e;

  function automatic logic [POP_W-1:0] popcount(input logic [CODE_W-1:0] v);
    logic [POP_W-1:0] n;
    n = '0;
    for (int i = 0; i < CODE_W; i++) n = n + POP_W'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/ecc_chunk_decode.sv
module ecc_chunk_decode
  import ecc_syn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] stored_code,
  output ecc_status_e       status,
  output logic [HALF_W-1:0] loc
);
  logic [CODE_W-1:0] syn_c;
  logic [HALF_W-1:0] fold_c;
  logic              zero_c;

  logic              v1_q;
  logic [HALF_W-1:0] syn_lo_q;
  logic [POP_W-1:0]  pop_q;
  logic              comp_q;
  logic              zero_q;
  ecc_status_e       class_c;

  assign syn_c  = calc_code ^ stored_code;
  assign fold_c = (calc_code[HALF_W-1:0] ^ calc_code[CODE_W-1:HALF_W]) ^
                  (stored_code[HALF_W-1:0] ^ stored_code[CODE_W-1:HALF_W]);
  assign zero_c = (syn_c == '0) || (calc_code == '0) || (stored_code == '0);

  // stage 1: syndrome, population count and pair check
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q     <= 1'b0;
      syn_lo_q <= '0;
      pop_q    <= '0;
      comp_q   <= 1'b0;
      zero_q   <= 1'b1;
    end else begin
      v1_q <= start;
      if (start) begin
        syn_lo_q <= syn_c[HALF_W-1:0];
        pop_q    <= popcount(syn_c);
        comp_q   <= (fold_c == '1);
        zero_q   <= zero_c;
      end
    end
  end

  always_comb begin
    if (zero_q)                                      class_c = ST_NONE;
    else if (pop_q == POP_W'(1))                     class_c = ST_ECC;
    else if (pop_q == POP_W'(HALF_W) && comp_q)      class_c = ST_CORR;
    else                                             class_c = ST_UNCORR;
  end

  // stage 2: classification result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= ST_NONE;
      loc    <= '0;
    end else if (v1_q) begin
      status <= class_c;
      loc    <= syn_lo_q;
    end
  end

  a_r3_zero_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q && zero_q |=> status == ST_NONE);
  a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q && !zero_q && pop_q == POP_W'(1) |=> status == ST_ECC);
  a_r6_odd_count: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q && !zero_q && pop_q != POP_W'(1) && pop_q != POP_W'(HALF_W)
    |=> status == ST_UNCORR);
endmodule

// File: rtl/ecc_status_merge.sv
module ecc_status_merge
  import ecc_syn_pkg::*;
#(
  parameter int CHUNKS = 2
) (
  input  logic [CHUNKS*2-1:0] st_vec,
  output logic [1:0]          merged
);
  always_comb begin
    merged = ST_NONE;
    for (int c = 0; c < CHUNKS; c++)
      if (st_vec[c*2 +: 2] > merged) merged = st_vec[c*2 +: 2];
  end
endmodule

// File: rtl/ecc_fix_port.sv
module ecc_fix_port
  import ecc_syn_pkg::*;
#(
  parameter int CHUNKS = 2,
  parameter int IDX_W  = 1,
  parameter int ADDR_W = IDX_W + OFFS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CHUNKS*2-1:0]      chunk_status,
  input  logic [CHUNKS*OFFS_W-1:0] err_offset,
  input  logic [CHUNKS*BIT_W-1:0]  err_bit,
  input  logic                     fix_valid,
  output logic                     fix_ready,
  input  logic [ADDR_W-1:0]        fix_addr,
  input  logic [BYTE_W-1:0]        fix_data,
  output logic                     fixo_valid,
  input  logic                     fixo_ready,
  output logic [BYTE_W-1:0]        fixo_data
);
  logic [IDX_W-1:0]  idx;
  logic [OFFS_W-1:0] off;
  logic [BYTE_W-1:0] flip;

  assign idx       = fix_addr[ADDR_W-1 -: IDX_W];
  assign off       = fix_addr[OFFS_W-1:0];
  assign fix_ready = !fixo_valid || fixo_ready;

  always_comb begin
    flip = '0;
    for (int c = 0; c < CHUNKS; c++)
      if (idx == IDX_W'(c) && chunk_status[c*2 +: 2] == ST_CORR &&
          off == err_offset[c*OFFS_W +: OFFS_W])
        flip = flip | (BYTE_W'(1) << err_bit[c*BIT_W +: BIT_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fixo_valid <= 1'b0;
      fixo_data  <= '0;
    end else if (fix_ready) begin
      fixo_valid <= fix_valid;
      if (fix_valid) fixo_data <= fix_data ^ flip;
    end
  end

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fixo_valid && !fixo_ready |=> fixo_valid && $stable(fixo_data));
  a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid && fix_ready && flip == '0 |=> fixo_data == $past(fix_data));
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
  import ecc_syn_pkg::*;
#(
  parameter  int CHUNKS  = 2,
  localparam int CHUNK_W = CODE_BYTES * BYTE_W,
  localparam int IDX_W   = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
  localparam int ADDR_W  = IDX_W + OFFS_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      dual_mode,
  input  logic [CHUNKS*CHUNK_W-1:0] calc_code,
  input  logic [CHUNKS*CHUNK_W-1:0] stored_code,
  output logic                      done,
  output logic [1:0]                status,
  output logic [CHUNKS*2-1:0]       chunk_status,
  output logic [CHUNKS*OFFS_W-1:0]  err_offset,
  output logic [CHUNKS*BIT_W-1:0]   err_bit,
  input  logic                      fix_valid,
  output logic                      fix_ready,
  input  logic [ADDR_W-1:0]         fix_addr,
  input  logic [BYTE_W-1:0]         fix_data,
  output logic                      fixo_valid,
  input  logic                      fixo_ready,
  output logic [BYTE_W-1:0]         fixo_data
);
  logic v1_q, dual1_q, dual2_q;
  ecc_status_e       st_raw  [CHUNKS];
  logic [HALF_W-1:0] loc_raw [CHUNKS];
  logic [CHUNKS-1:0] unused_pad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q    <= 1'b0;
      done    <= 1'b0;
      dual1_q <= 1'b0;
      dual2_q <= 1'b0;
    end else begin
      v1_q <= start;
      done <= v1_q;
      if (start) dual1_q <= dual_mode;
      if (v1_q)  dual2_q <= dual1_q;
    end
  end

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    ecc_chunk_decode u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .calc_code  (calc_code[c*CHUNK_W +: CODE_W]),
      .stored_code(stored_code[c*CHUNK_W +: CODE_W]),
      .status     (st_raw[c]),
      .loc        (loc_raw[c])
    );
    assign unused_pad[c] = ^{calc_code[c*CHUNK_W+CODE_W +: CHUNK_W-CODE_W],
                             stored_code[c*CHUNK_W+CODE_W +: CHUNK_W-CODE_W]};
    assign chunk_status[c*2 +: 2] = (c == 0 || dual2_q) ? st_raw[c] : ST_NONE;
    assign err_offset[c*OFFS_W +: OFFS_W] = loc_raw[c][HALF_W-1:BIT_W];
    assign err_bit[c*BIT_W +: BIT_W]      = loc_raw[c][BIT_W-1:0];
  end

  ecc_status_merge #(.CHUNKS(CHUNKS)) u_merge (
    .st_vec(chunk_status),
    .merged(status)
  );

  ecc_fix_port #(.CHUNKS(CHUNKS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_fix (
    .clk         (clk),
    .rst_n       (rst_n),
    .chunk_status(chunk_status),
    .err_offset  (err_offset),
    .err_bit     (err_bit),
    .fix_valid   (fix_valid),
    .fix_ready   (fix_ready),
    .fix_addr    (fix_addr),
    .fix_data    (fix_data),
    .fixo_valid  (fixo_valid),
    .fixo_ready  (fixo_ready),
    .fixo_data   (fixo_data)
  );

  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 done);
  a_r7_merge_worst: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_status[1:0] == ST_UNCORR |-> status == ST_UNCORR);
endmodule

// File: tb/tb_ecc_syndrome_corrector.sv
module tb_ecc_syndrome_corrector;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, dual_mode;
  logic [47:0] calc_code, stored_code;
  logic        done;
  logic [1:0]  status;
  logic [3:0]  chunk_status;
  logic [15:0] err_offset;
  logic [5:0]  err_bit;
  logic        fix_valid, fix_ready, fixo_valid, fixo_ready;
  logic [8:0]  fix_addr;
  logic [7:0]  fix_data, fixo_data;

  ecc_syndrome_corrector dut (.*);

  int n_run = 0, n_fail = 0;

  typedef struct {
    string      tag;
    logic [1:0] st;
    logic [3:0] cst;
    logic [15:0] offs;
    logic [5:0] bits;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [1:0] ref_status(logic [23:0] cb, logic [23:0] sb);
    logic [21:0] c, s, syn;
    c = cb[21:0]; s = sb[21:0]; syn = c ^ s;
    if (syn == 0 || c == 0 || s == 0) return 2'd0;
    if ($countones(syn) == 1) return 2'd1;
    if ($countones(syn) == 11 && (syn[10:0] ^ syn[21:11]) == 11'h7FF) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [21:0] corr_syn(logic [10:0] l);
    return {~l, l};
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // driver: pushes expected results, then issues start
  task automatic run_case(string tag, logic [23:0] c0, logic [23:0] s0,
                          logic [23:0] c1, logic [23:0] s1, logic dual);
    exp_t e;
    logic [1:0] st0, st1;
    st0 = ref_status(c0, s0);
    st1 = dual ? ref_status(c1, s1) : 2'd0;
    e.tag = tag;
    e.st = (st0 > st1) ? st0 : st1;
    e.cst = {st1, st0};
    e.offs = {c1[10:3] ^ s1[10:3], c0[10:3] ^ s0[10:3]};
    e.bits = {c1[2:0] ^ s1[2:0], c0[2:0] ^ s0[2:0]};
    exp_q.push_back(e);
    @(negedge clk);
    calc_code = {c1, c0}; stored_code = {s1, s0}; dual_mode = dual; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk({tag, " R2 done pulse ended"}, 32'(done), 32'd0);
  endtask

  // monitor: pops and compares on each done
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R2: actual unexpected done expected none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " R7 merged status"}, 32'(status), 32'(e.st));
        chk({e.tag, " chunk status"}, 32'(chunk_status), 32'(e.cst));
        for (int c = 0; c < 2; c++)
          if (e.cst[c*2 +: 2] == 2'd2) begin
            chk({e.tag, " R5 offset"}, 32'(err_offset[c*8 +: 8]), 32'(e.offs[c*8 +: 8]));
            chk({e.tag, " R5 bit"}, 32'(err_bit[c*3 +: 3]), 32'(e.bits[c*3 +: 3]));
          end
      end
    end
  end

  task automatic fix_once(string tag, logic [8:0] a, logic [7:0] d, logic [7:0] expd);
    @(negedge clk);
    fixo_ready = 1'b1; fix_valid = 1'b1; fix_addr = a; fix_data = d;
    @(negedge clk);
    fix_valid = 1'b0;
    chk({tag, " valid"}, 32'(fixo_valid), 32'd1);
    chk({tag, " data"}, 32'(fixo_data), 32'(expd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R2: actual hang expected completion (watchdog)");
    summary();
    $finish;
  end

  initial begin
    logic [23:0] base;
    base = 24'h0ABCDE;
    rst_n = 1'b0; start = 1'b0; dual_mode = 1'b0;
    calc_code = '0; stored_code = '0;
    fix_valid = 1'b0; fix_addr = '0; fix_data = '0; fixo_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 done in reset", 32'(done), 32'd0);
    chk("R10 status in reset", 32'(status), 32'd0);
    chk("R10 chunk status in reset", 32'(chunk_status), 32'd0);
    chk("R10 fixo_valid in reset", 32'(fixo_valid), 32'd0);
    rst_n = 1'b1;

    run_case("R3 zero syndrome", 24'h155AA3, 24'h155AA3, 0, 0, 1'b0);
    run_case("R1 pad bits ignored", 24'hC12345, 24'h012345, 0, 0, 1'b0);
    run_case("R3 zero code", 24'h000000, 24'h000123, 0, 0, 1'b0);
    run_case("R4 single bit", base, base ^ 24'h200000, 0, 0, 1'b0);
    run_case("R6 two bits", base, base ^ 24'h000003, 0, 0, 1'b0);
    fix_once("R8 uncorrectable no flip", 9'h000, 8'h00, 8'h00);
    run_case("R6 eleven not paired", base, base ^ 24'h0013FF, 0, 0, 1'b0);

    run_case("R5 correctable", base, base ^ {2'b0, corr_syn(11'h2A5)}, 0, 0, 1'b0);
    fix_once("R8 flip at offset 54 bit 5", 9'h054, 8'h00, 8'h20);
    fix_once("R8 other offset unchanged", 9'h055, 8'h3C, 8'h3C);
    fix_once("R8 disabled chunk unchanged", 9'h154, 8'h00, 8'h00);

    // R9 stall: output must hold while consumer not ready
    @(negedge clk);
    fixo_ready = 1'b0; fix_valid = 1'b1; fix_addr = 9'h054; fix_data = 8'h0F;
    @(negedge clk);
    chk("R9 stalled fix_ready low", 32'(fix_ready), 32'd0);
    chk("R9 first byte out", 32'(fixo_data), 32'h2F);
    fix_data = 8'h81;
    @(negedge clk);
    chk("R9 held valid", 32'(fixo_valid), 32'd1);
    chk("R9 held data", 32'(fixo_data), 32'h2F);
    fixo_ready = 1'b1;
    @(negedge clk);
    fix_valid = 1'b0;
    chk("R9 second byte after release", 32'(fixo_data), 32'hA1);
    @(negedge clk);
    chk("R9 drained", 32'(fixo_valid), 32'd0);

    run_case("R7 dual worst of halves", base, base ^ {2'b0, corr_syn(11'h2A5)},
             24'h033333, 24'h033330, 1'b1);
    run_case("R7 single mode ignores chunk 1", base, base ^ {2'b0, corr_syn(11'h2A5)},
             24'h033333, 24'h033330, 1'b0);
    run_case("R7 dual both correctable", base, base ^ {2'b0, corr_syn(11'h2A5)},
             24'h1F0F0F, 24'h1F0F0F ^ {2'b0, corr_syn(11'h013)}, 1'b1);
    fix_once("R8 chunk 1 flip", 9'h102, 8'hFF, 8'hF7);
    fix_once("R8 chunk 0 flip in dual", 9'h054, 8'hFF, 8'hDF);
    run_case("R7 dual check-bit only", base, base ^ 24'h000400,
             24'h1F0F0F, 24'h1F0F0F, 1'b1);

    repeat (3) @(negedge clk);
    chk("R2 every start produced done", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end
endmodule